// File: doc/BRIEF.md
# Tiled Surface Pitch Validator

This block decides whether a request to lay out a graphics surface in a tiled format is legal. A request names the tiling layout (linear, X-tiled or Y-tiled), the row pitch in bytes, the object size in bytes, the hardware generation class (early, middle or late), and whether Y tiles are 128 bytes wide. It also says whether the object is already placed in the aperture, and if so at which byte offset. The legality rules depend on the generation. Late parts bound the pitch, counted in 128-byte units, by a programmable maximum. Older parts cap the pitch at 8192 bytes and require it to be a power of two that is no smaller than one tile.

Alongside the verdict, the block finds the smallest power-of-two fence region that covers the object. It starts from a generation-dependent base and doubles it once per clock. On the older generations a placed, tiled object must sit at an offset that is a multiple of that region. A response pulse returns accept or reject, a reason code and the region size. Requests that arrive while a check is in progress are dropped.

Top module: `tile_pitch_check`

## Requirements
- R1: A linear request (layout code 0) is always accepted with reason 0, whatever its pitch, size, offset or generation.
- R2: The tile width is 128 bytes when the generation is early (code 0), or when the layout is Y (code 2 or 3) and the narrow-Y flag is set. In every other case it is 512 bytes.
- R3: On the late generation (code 2 or 3), a tiled request whose pitch divided by 128 (rounded down) exceeds `max_pitch` is rejected with reason 1 (pitch too large).
- R4: On the late generation, a tiled request whose pitch is not a multiple of the tile width is rejected with reason 2 (bad pitch alignment).
- R5: On the early and middle generations (codes 0 and 1), a tiled request whose pitch exceeds 8192 bytes is rejected with reason 1.
- R6: On the early and middle generations, a tiled request whose pitch is smaller than the tile width, or is not a power of two, is rejected with reason 2.
- R7: `fence_size` is the smallest value at least `obj_size` in the series base, 2·base, 4·base, and so on. The base is 512 KiB on the early generation and 1 MiB on the others. The series stops at 2^(SIZE_W-1).
- R8: The region doubles once per clock. `rsp_valid` is a one-cycle pulse seen k+1 clocks after the edge that accepts the request, where k is the number of doublings. `busy` is high from that edge until the response.
- R9: On the early and middle generations, a tiled request with `bound` set and an offset that is not a multiple of `fence_size` is rejected with reason 3. On the late generation, or with `bound` clear, the offset is not checked.
- R10: When several faults apply, reason 1 takes precedence over reason 2, and reason 2 over reason 3. `rsp_ok` is 1 exactly when the reason is 0.
- R11: A `req_valid` seen while `busy` is high is ignored: it produces no response and does not alter the result of the check in progress.
- R12: After reset, `rsp_valid`, `rsp_ok`, `busy`, `rsp_reason` and `fence_size` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken when not busy |
| tile_mode | input | 2 | 0 linear, 1 X, 2 or 3 Y |
| gen_sel | input | 2 | 0 early, 1 middle, 2 or 3 late |
| narrow_y | input | 1 | Y tiles are 128 bytes wide |
| stride | input | STRIDE_W | Row pitch in bytes |
| obj_size | input | SIZE_W | Object size in bytes |
| bound | input | 1 | Object already placed in the aperture |
| obj_offset | input | SIZE_W | Aperture byte offset of a placed object |
| max_pitch | input | PITCH_W | Late-generation pitch limit in 128-byte units |
| busy | output | 1 | A check is in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_ok | output | 1 | Request accepted |
| rsp_reason | output | 2 | 0 none, 1 pitch too large, 2 bad alignment, 3 fence misaligned |
| fence_size | output | SIZE_W | Smallest covering fence region in bytes |

## Verification
A wrong region register shows at the response in two ways. The latency comes out off by one or more clocks against k+1, and `fence_size` is either not a power of two or fails to cover the size. Both are visible on the very response that follows the bad doubling. A wrong captured field, or a wrong tile-width choice, flips the reason code of that same response, so every rule is exercised at pitches just either side of its threshold. A response that is dropped, or that appears twice, is caught by the latency bound and by watching `rsp_valid` across the ignored-request window.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
   localparam logic [1:0] GEN_EARLY = 2'd0;
   localparam logic [1:0] GEN_MID   = 2'd1;

   typedef enum logic [1:0] {
      RS_NONE  = 2'd0,
      RS_WIDE  = 2'd1,
      RS_ALIGN = 2'd2,
      RS_FENCE = 2'd3
   } reason_e;
endpackage

// File: rtl/tpc_rules.sv
module tpc_rules #(
   parameter int STRIDE_W    = 18,
   parameter int PITCH_W     = 10,
   parameter int TW_NARROW   = 128,
   parameter int TW_WIDE     = 512,
   parameter int UNIT_LOG2   = 7,
   parameter int OLD_MAX_PIT = 8192
) (
   input  logic [1:0]          gen,
   input  logic [1:0]          mode,
   input  logic                narrow_y,
   input  logic [STRIDE_W-1:0] stride,
   input  logic [PITCH_W-1:0]  max_pitch,
   output tpc_pkg::reason_e    pre_reason
);
   import tpc_pkg::*;

   localparam logic [STRIDE_W-1:0] NARROW = STRIDE_W'(TW_NARROW);
   localparam logic [STRIDE_W-1:0] WIDE   = STRIDE_W'(TW_WIDE);
   localparam logic [STRIDE_W-1:0] OLDMAX = STRIDE_W'(OLD_MAX_PIT);

   logic                is_old;
   logic [STRIDE_W-1:0] tw;
   logic [STRIDE_W-1:0] units;
   logic                too_wide, misaligned, pow2;

   always_comb begin
      is_old = (gen == GEN_EARLY) || (gen == GEN_MID);
      tw     = ((gen == GEN_EARLY) || (mode[1] && narrow_y)) ? NARROW : WIDE;
      units  = stride >> UNIT_LOG2;
      pow2   = (stride != '0) && ((stride & (stride - 1'b1)) == '0);
      if (is_old) begin
         too_wide   = stride > OLDMAX;
         misaligned = (stride < tw) || !pow2;
      end else begin
         too_wide   = units > STRIDE_W'(max_pitch);
         misaligned = (stride & (tw - 1'b1)) != '0;
      end
      if (too_wide)        pre_reason = RS_WIDE;
      else if (misaligned) pre_reason = RS_ALIGN;
      else                 pre_reason = RS_NONE;
   end
endmodule

// File: rtl/tpc_fence_walk.sv
module tpc_fence_walk #(
   parameter int SIZE_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [SIZE_W-1:0] base,
   input  logic [SIZE_W-1:0] size,
   output logic [SIZE_W-1:0] cur,
   output logic              running,
   output logic              done
);
   logic [SIZE_W-1:0] size_r;

   assign done = running && ((cur >= size_r) || cur[SIZE_W-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur     <= '0;
         size_r  <= '0;
         running <= 1'b0;
      end else if (start) begin
         cur     <= base;
         size_r  <= size;
         running <= 1'b1;
      end else if (done) begin
         running <= 1'b0;
      end else if (running) begin
         cur     <= cur << 1;
      end
   end
endmodule

// File: rtl/tile_pitch_check.sv
module tile_pitch_check #(
   parameter int STRIDE_W    = 18,
   parameter int SIZE_W      = 28,
   parameter int PITCH_W     = 10,
   parameter int TW_NARROW   = 128,
   parameter int TW_WIDE     = 512,
   parameter int UNIT_LOG2   = 7,
   parameter int OLD_MAX_PIT = 8192,
   parameter int EARLY_LOG2  = 19,
   parameter int MID_LOG2    = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [1:0]          tile_mode,
   input  logic [1:0]          gen_sel,
   input  logic                narrow_y,
   input  logic [STRIDE_W-1:0] stride,
   input  logic [SIZE_W-1:0]   obj_size,
   input  logic                bound,
   input  logic [SIZE_W-1:0]   obj_offset,
   input  logic [PITCH_W-1:0]  max_pitch,
   output logic                busy,
   output logic                rsp_valid,
   output logic                rsp_ok,
   output logic [1:0]          rsp_reason,
   output logic [SIZE_W-1:0]   fence_size
);
   import tpc_pkg::*;

   localparam logic [SIZE_W-1:0] EARLY_BASE = SIZE_W'(1) << EARLY_LOG2;
   localparam logic [SIZE_W-1:0] MID_BASE   = SIZE_W'(1) << MID_LOG2;

   generate
      if (PITCH_W > STRIDE_W) begin : g_bad_pitch
         $error("PITCH_W must not exceed STRIDE_W");
      end
      if (SIZE_W <= MID_LOG2 || EARLY_LOG2 > MID_LOG2) begin : g_bad_size
         $error("SIZE_W too small for the fence bases");
      end
      if ((TW_NARROW & (TW_NARROW - 1)) != 0 || (TW_WIDE & (TW_WIDE - 1)) != 0) begin : g_bad_tw
         $error("tile widths must be powers of two");
      end
      if (OLD_MAX_PIT >= (1 << STRIDE_W)) begin : g_bad_max
         $error("STRIDE_W too small for the old pitch cap");
      end
   endgenerate

   logic                accept;
   logic [1:0]          gen_q, mode_q;
   logic                ny_q, bound_q;
   logic [STRIDE_W-1:0] stride_q;
   logic [SIZE_W-1:0]   off_q, sz_q;
   logic [PITCH_W-1:0]  maxp_q;
   logic [SIZE_W-1:0]   walk_cur;
   logic                walk_run, walk_done;
   reason_e             pre_reason, fin_reason;
   logic                off_bad;

   assign accept = req_valid && !walk_run;
   assign busy   = walk_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_q    <= '0;
         mode_q   <= '0;
         ny_q     <= 1'b0;
         bound_q  <= 1'b0;
         stride_q <= '0;
         off_q    <= '0;
         sz_q     <= '0;
         maxp_q   <= '0;
      end else if (accept) begin
         gen_q    <= gen_sel;
         mode_q   <= tile_mode;
         ny_q     <= narrow_y;
         bound_q  <= bound;
         stride_q <= stride;
         off_q    <= obj_offset;
         sz_q     <= obj_size;
         maxp_q   <= max_pitch;
      end
   end

   tpc_rules #(
      .STRIDE_W(STRIDE_W), .PITCH_W(PITCH_W), .TW_NARROW(TW_NARROW),
      .TW_WIDE(TW_WIDE), .UNIT_LOG2(UNIT_LOG2), .OLD_MAX_PIT(OLD_MAX_PIT)
   ) u_rules (
      .gen(gen_q), .mode(mode_q), .narrow_y(ny_q), .stride(stride_q),
      .max_pitch(maxp_q), .pre_reason(pre_reason)
   );

   tpc_fence_walk #(.SIZE_W(SIZE_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .start(accept),
      .base((gen_sel == GEN_EARLY) ? EARLY_BASE : MID_BASE),
      .size(obj_size), .cur(walk_cur), .running(walk_run), .done(walk_done)
   );

   always_comb begin
      off_bad = ((gen_q == GEN_EARLY) || (gen_q == GEN_MID)) && bound_q &&
                ((off_q & (walk_cur - 1'b1)) != '0);
      if (mode_q == 2'd0)          fin_reason = RS_NONE;
      else if (pre_reason != RS_NONE) fin_reason = pre_reason;
      else if (off_bad)            fin_reason = RS_FENCE;
      else                         fin_reason = RS_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_ok     <= 1'b0;
         rsp_reason <= '0;
         fence_size <= '0;
      end else begin
         rsp_valid <= walk_done;
         if (walk_done) begin
            rsp_ok     <= (fin_reason == RS_NONE);
            rsp_reason <= fin_reason;
            fence_size <= walk_cur;
         end
      end
   end
endmodule

module tile_pitch_check_chk #(
   parameter int SIZE_W = 28
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              rsp_valid,
   input logic              rsp_ok,
   input logic [1:0]        rsp_reason,
   input logic [SIZE_W-1:0] fence_size,
   input logic [SIZE_W-1:0] walk_cur,
   input logic [SIZE_W-1:0] sz_q,
   input logic [1:0]        mode_q
);
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   a_r8_not_busy_at_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !busy);
   a_r8_double_per_clk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (walk_cur == ($past(walk_cur) << 1)));
   a_r7_fence_pow2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot(fence_size));
   a_r7_fence_covers: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ((fence_size >= sz_q) || fence_size[SIZE_W-1]));
   a_r10_ok_matches_reason: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_ok == (rsp_reason == 2'd0)));
   a_r1_linear_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && mode_q == 2'd0) |-> rsp_ok);
endmodule

bind tile_pitch_check tile_pitch_check_chk #(.SIZE_W(SIZE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
   .rsp_ok(rsp_ok), .rsp_reason(rsp_reason), .fence_size(fence_size),
   .walk_cur(walk_cur), .sz_q(sz_q), .mode_q(mode_q)
);

// File: tb/tile_pitch_check_test.sv
module tile_pitch_check_test;
   localparam int SW = 18;
   localparam int ZW = 28;
   localparam int PW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    tile_mode = '0, gen_sel = '0;
   logic          narrow_y = 1'b0, bound = 1'b0;
   logic [SW-1:0] stride = '0;
   logic [ZW-1:0] obj_size = '0, obj_offset = '0;
   logic [PW-1:0] max_pitch = '0;
   logic          busy, rsp_valid, rsp_ok;
   logic [1:0]    rsp_reason;
   logic [ZW-1:0] fence_size;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   tile_pitch_check uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .tile_mode(tile_mode),
      .gen_sel(gen_sel), .narrow_y(narrow_y), .stride(stride), .obj_size(obj_size),
      .bound(bound), .obj_offset(obj_offset), .max_pitch(max_pitch),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
      .rsp_reason(rsp_reason), .fence_size(fence_size)
   );

   task automatic chk(input bit good, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Expected verdict, region and doublings, from the requirements
   function automatic void model(input logic [1:0] g, input logic [1:0] m, input logic ny,
                                 input longint s, input longint sz, input logic bd,
                                 input longint off, input longint mp,
                                 output int reason, output longint fence, output int k);
      longint tw;
      bit old_gen, pow2;
      fence = (g == 2'd0) ? (64'd1 << 19) : (64'd1 << 20);   // R7
      k = 0;
      while (fence < sz && fence != (64'd1 << (ZW-1))) begin
         fence = fence << 1;
         k++;
      end
      tw = ((g == 2'd0) || (m[1] && ny)) ? 128 : 512;          // R2
      old_gen = (g == 2'd0) || (g == 2'd1);
      pow2 = (s != 0) && ((s & (s - 1)) == 0);
      reason = 0;
      if (m == 2'd0) reason = 0;                                // R1
      else if (old_gen) begin
         if (s > 8192) reason = 1;                              // R5
         else if (s < tw || !pow2) reason = 2;                  // R6
         else if (bd && (off % fence) != 0) reason = 3;         // R9
      end else begin
         if ((s / 128) > mp) reason = 1;                        // R3
         else if ((s % tw) != 0) reason = 2;                    // R4
      end
   endfunction

   task automatic run_req(input logic [1:0] g, input logic [1:0] m, input logic ny,
                          input longint s, input longint sz, input logic bd,
                          input longint off, input longint mp,
                          input int want_reason, input string tag);
      int er, ek, n;
      longint ef;
      bit seen;
      model(g, m, ny, s, sz, bd, off, mp, er, ef, ek);
      @(negedge clk);
      gen_sel = g; tile_mode = m; narrow_y = ny; stride = SW'(s);
      obj_size = ZW'(sz); bound = bd; obj_offset = ZW'(off); max_pitch = PW'(mp);
      req_valid = 1'b1;
      @(posedge clk); #1;
      req_valid = 1'b0;
      chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
      n = 0; seen = 0;
      while (!seen && n < 64) begin
         @(posedge clk); #1;
         n++;
         if (rsp_valid) seen = 1;
      end
      chk(seen && n == ek + 1, "R8", "response latency", n, ek + 1);
      chk(fence_size == ZW'(ef), "R7", "fence size", fence_size, ef);
      chk(rsp_reason == 2'(er), tag, "reason", rsp_reason, er);
      chk(rsp_ok == (er == 0), "R10", "ok flag", rsp_ok, (er == 0));
      if (want_reason >= 0)
         chk(er == want_reason, tag, "directed reason", rsp_reason, want_reason);
      @(posedge clk); #1;
      chk(rsp_valid == 1'b0, "R8", "pulse width", rsp_valid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int pulses;
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1;
      // R12 reset state
      chk(rsp_valid == 0 && busy == 0, "R12", "valid/busy at reset", {rsp_valid, busy}, 0);
      chk(rsp_ok == 0 && rsp_reason == 0, "R12", "ok/reason at reset", {rsp_ok, rsp_reason}, 0);
      chk(fence_size == 0, "R12", "fence at reset", fence_size, 0);
      @(negedge clk) rst_n = 1'b1;

      // R1 linear with hostile fields
      run_req(2'd2, 2'd0, 0, 3, 5, 1, 7, 0, 0, "R1");
      run_req(2'd0, 2'd0, 0, 99999, 12345, 1, 3, 0, 0, "R1");
      // R3 / R4 late generation
      run_req(2'd2, 2'd1, 0, 1152, 4096, 0, 0, 8, 1, "R3");
      run_req(2'd2, 2'd1, 0, 1024, 4096, 0, 0, 8, 0, "R3");
      run_req(2'd3, 2'd1, 0, 640, 4096, 0, 0, 100, 2, "R4");
      run_req(2'd2, 2'd2, 1, 640, 4096, 0, 0, 100, 0, "R2");
      run_req(2'd2, 2'd2, 0, 640, 4096, 0, 0, 100, 2, "R2");
      // R5 / R6 older generations
      run_req(2'd0, 2'd1, 0, 16384, 4096, 0, 0, 0, 1, "R5");
      run_req(2'd0, 2'd1, 0, 8192, 4096, 0, 0, 0, 0, "R5");
      run_req(2'd1, 2'd1, 0, 256, 4096, 0, 0, 0, 2, "R6");
      run_req(2'd1, 2'd1, 0, 1536, 4096, 0, 0, 0, 2, "R6");
      run_req(2'd0, 2'd1, 0, 256, 4096, 0, 0, 0, 0, "R2");
      run_req(2'd1, 2'd2, 1, 128, 4096, 0, 0, 0, 0, "R2");
      // R10 precedence
      run_req(2'd0, 2'd1, 0, 12000, 4096, 1, 1, 0, 1, "R10");
      run_req(2'd1, 2'd1, 0, 768, 3 << 19, 1, 1 << 19, 0, 2, "R10");
      // R7 region sizes, including the cap
      run_req(2'd0, 2'd1, 0, 512, 0, 0, 0, 0, 0, "R7");
      run_req(2'd1, 2'd1, 0, 512, (1 << 20) + 1, 0, 0, 0, 0, "R7");
      run_req(2'd0, 2'd1, 0, 512, 3 << 20, 0, 0, 0, 0, "R7");
      run_req(2'd0, 2'd0, 0, 0, (64'd1 << 27) + 5, 0, 0, 0, 0, "R7");
      // R9 offset alignment
      run_req(2'd1, 2'd1, 0, 2048, 3 << 19, 1, 1 << 20, 0, 3, "R9");
      run_req(2'd1, 2'd1, 0, 2048, 3 << 19, 1, 2 << 20, 0, 0, "R9");
      run_req(2'd2, 2'd1, 0, 2048, 3 << 19, 1, 1 << 20, 100, 0, "R9");
      run_req(2'd1, 2'd1, 0, 2048, 3 << 19, 0, 1 << 20, 0, 0, "R9");

      // R11: a second request during a long walk is dropped
      @(negedge clk);
      gen_sel = 2'd0; tile_mode = 2'd1; narrow_y = 0; stride = SW'(300);
      obj_size = ZW'(64'd1 << 26); bound = 0; obj_offset = '0; max_pitch = '0;
      req_valid = 1'b1;
      @(posedge clk); #1;
      gen_sel = 2'd2; tile_mode = 2'd0; obj_size = '0;
      repeat (2) @(posedge clk);
      #1 req_valid = 1'b0;
      pulses = 0;
      repeat (20) begin
         @(posedge clk); #1;
         if (rsp_valid) begin
            pulses++;
            chk(rsp_reason == 2'd2, "R11", "reason of first request", rsp_reason, 2);
            chk(fence_size == ZW'(64'd1 << 26), "R11", "fence of first request", fence_size, 64'd1 << 26);
         end
      end
      chk(pulses == 1, "R11", "response count", pulses, 1);

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         longint s, sz, off;
         int cat;
         cat = $urandom % 4;
         case (cat)
            0: s = 64'd1 << ($urandom % 16);
            1: s = ($urandom % 64) * 128;
            2: s = ($urandom % 40) * 512;
            default: s = $urandom % 20000;
         endcase
         sz = $urandom % (1 << 26);
         off = ($urandom % 2) ? (($urandom % 64) * (64'd1 << 20)) : ($urandom % (1 << 27));
         run_req(2'($urandom), 2'($urandom), 1'($urandom), s, sz, 1'($urandom),
                 off, $urandom % 128, -1, "R1-R10 random");
      end

      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule